// File: doc/BRIEF.md
# Single-Lane Vector Arithmetic Unit

This block is one pipelined vector functional unit with a single lane. After an operation is issued, it reads one element index per clock from an external vector register file and pushes each element through a fixed-latency pipeline. It writes each result element back to a destination vector register. Integer add and multiply stand in for the arithmetic. Every operand is `W` bits wide, and results wrap modulo 2^W.

The unit has two operand forms. In the vector-vector form, both operands come from vector registers. In the vector-scalar form, the scalar value on the issue port is copied into a latch when the operation is accepted, and that one value is used for every element. A reduction operation counts the nonzero elements of one source register. Its result goes to a scalar register through a dedicated result port, and no vector write takes place.

Control is a four-state machine:
- `ST_IDLE`: accepts an issue with a legal opcode and moves to `ST_STREAM`.
- `ST_STREAM`: issues one element read per clock. After the read of element `VLEN-1` it moves to `ST_DRAIN`.
- `ST_DRAIN`: waits for the last element to leave the pipeline. It then returns to `ST_IDLE` for arithmetic operations, or moves to `ST_REPORT` for the count.
- `ST_REPORT`: presents the count for one clock, then returns to `ST_IDLE`.

Top module: `vec_lane_unit`

## Requirements
- R1: After reset, or when reset is asserted in the middle of an operation, the unit is idle: `issue_ready`=1, and `rd_en`, `wr_en` and `sres_valid` are all 0.
- R2: Opcode 3'b000 (add, vector-vector) writes `vd[i] = va[i] + vb[i]` mod 2^W for every i in 0..VLEN-1.
- R3: Opcode 3'b001 (add, vector-scalar) writes `vd[i] = va[i] + s` mod 2^W, where s is the scalar on the issue port.
- R4: Opcode 3'b010 (multiply, vector-vector) writes the low W bits of `va[i] * vb[i]` to `vd[i]`.
- R5: Opcode 3'b011 (multiply, vector-scalar) writes the low W bits of `va[i] * s` to `vd[i]`.
- R6: The scalar is captured in the cycle the issue is accepted. Changing `issue_scalar` afterwards has no effect on any element result.
- R7: Opcode 3'b100 counts the nonzero elements of `va`. It produces no vector write. It raises `sres_valid` for exactly one cycle, LAT+VLEN+1 cycles after the accept edge, with the count on `sres_data` and the scalar destination index on `sres_reg`.
- R8: Element k is read in cycle 1+k after the accept cycle and written back LAT cycles later. Write-backs occur on consecutive cycles in ascending index order, to register `issue_vd`.
- R9: `issue_ready` is 0 from the cycle after an accept through the last write-back (or through the report cycle of a count). A new issue presented while the unit is busy is ignored.
- R10: Opcodes 3'b101 to 3'b111 are not accepted. The unit stays idle, and no read, write or scalar result follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue request |
| issue_op | input | 3 | Opcode |
| issue_vd | input | RW | Destination vector register |
| issue_va | input | RW | First source vector register |
| issue_vb | input | RW | Second source vector register |
| issue_sd | input | SW | Destination scalar register for the count |
| issue_scalar | input | W | Scalar operand for vector-scalar forms |
| issue_ready | output | 1 | Unit idle; an issue is accepted this cycle |
| rd_en | output | 1 | Element read strobe |
| rd_a_reg | output | RW | First read port register index |
| rd_b_reg | output | RW | Second read port register index |
| rd_idx | output | IW | Element index for both read ports |
| rd_a_data | input | W | Element from the first read port (combinational) |
| rd_b_data | input | W | Element from the second read port (combinational) |
| wr_en | output | 1 | Element write strobe |
| wr_reg | output | RW | Destination register of the write |
| wr_idx | output | IW | Element index of the write |
| wr_data | output | W | Element value written |
| sres_valid | output | 1 | Scalar result strobe |
| sres_reg | output | SW | Scalar destination register |
| sres_data | output | W | Nonzero-element count |

## Verification
A corrupted element index or a corrupted pipeline valid bit shows up at the write port within LAT cycles. It appears as a write out of order, at the wrong time, or to the wrong register. A state machine that leaves `ST_DRAIN` early, or a latched scalar that follows the port, shows up as wrong element values in the register file once the operation completes. An accumulator that is not cleared at issue shows up as a wrong count on the next reduction's single report cycle. A busy flag that drops early shows up as an intruding issue corrupting an unrelated register within a few cycles.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

    typedef enum logic [2:0] {
        OP_ADD_VV = 3'b000,
        OP_ADD_VS = 3'b001,
        OP_MUL_VV = 3'b010,
        OP_MUL_VS = 3'b011,
        OP_POPC   = 3'b100
    } vlu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STREAM,
        ST_DRAIN,
        ST_REPORT
    } vlu_state_e;

    function automatic logic op_legal(input logic [2:0] op);
        return op <= OP_POPC;
    endfunction

    function automatic logic op_uses_scalar(input logic [2:0] op);
        return (op == OP_ADD_VS) || (op == OP_MUL_VS);
    endfunction

    function automatic logic op_is_mul(input logic [2:0] op);
        return (op == OP_MUL_VV) || (op == OP_MUL_VS);
    endfunction

    function automatic logic op_is_popc(input logic [2:0] op);
        return op == OP_POPC;
    endfunction

endpackage

// File: rtl/vlu_ctrl.sv
module vlu_ctrl
    import vlu_pkg::*;
#(
    parameter int VLEN = 8,
    parameter int IW   = 3,
    parameter int RW   = 3,
    parameter int SW   = 3,
    parameter int W    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  logic [2:0]    issue_op,
    input  logic [RW-1:0] issue_vd,
    input  logic [RW-1:0] issue_va,
    input  logic [RW-1:0] issue_vb,
    input  logic [SW-1:0] issue_sd,
    input  logic [W-1:0]  issue_scalar,
    input  logic          pipe_out_valid,
    input  logic          pipe_out_last,
    output logic          issue_ready,
    output logic          start,
    output logic          rd_en,
    output logic [IW-1:0] rd_idx,
    output logic          rd_last,
    output logic          report,
    output logic [2:0]    op_q,
    output logic [RW-1:0] vd_q,
    output logic [RW-1:0] va_q,
    output logic [RW-1:0] vb_q,
    output logic [SW-1:0] sd_q,
    output logic [W-1:0]  scalar_q
);

    localparam logic [IW-1:0] LAST_IDX = IW'(VLEN - 1);

    vlu_state_e state_q, state_d;
    logic [IW-1:0] idx_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (issue_valid && op_legal(issue_op)) state_d = ST_STREAM;
            ST_STREAM: if (idx_q == LAST_IDX) state_d = ST_DRAIN;
            ST_DRAIN:  if (pipe_out_valid && pipe_out_last)
                           state_d = op_is_popc(op_q) ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        issue_ready = 1'b0;
        rd_en       = 1'b0;
        report      = 1'b0;
        unique case (state_q)
            ST_IDLE:   issue_ready = 1'b1;
            ST_STREAM: rd_en       = 1'b1;
            ST_DRAIN:  ;
            ST_REPORT: report      = 1'b1;
            default:   ;
        endcase
    end

    assign start   = issue_ready && issue_valid && op_legal(issue_op);
    assign rd_idx  = idx_q;
    assign rd_last = rd_en && (idx_q == LAST_IDX);

    // Issue latch and element index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            op_q     <= '0;
            vd_q     <= '0;
            va_q     <= '0;
            vb_q     <= '0;
            sd_q     <= '0;
            scalar_q <= '0;
        end else if (start) begin
            idx_q    <= '0;
            op_q     <= issue_op;
            vd_q     <= issue_vd;
            va_q     <= issue_va;
            vb_q     <= issue_vb;
            sd_q     <= issue_sd;
            scalar_q <= issue_scalar;
        end else if (rd_en) begin
            idx_q    <= idx_q + IW'(1);
        end
    end

endmodule

// File: rtl/vlu_exec.sv
module vlu_exec
    import vlu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b_vec,
    input  logic [W-1:0] scalar,
    output logic [W-1:0] result,
    output logic         nonzero
);

    logic [W-1:0] b_sel;

    always_comb begin
        b_sel = op_uses_scalar(op) ? scalar : b_vec;
        if (op_is_mul(op)) result = a * b_sel;
        else               result = a + b_sel;
        nonzero = (a != '0);
    end

endmodule

// File: rtl/vlu_pipe.sv
module vlu_pipe #(
    parameter int LAT = 3,
    parameter int W   = 16,
    parameter int IW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic [IW-1:0] in_idx,
    input  logic [W-1:0]  in_data,
    input  logic          in_nz,
    output logic          out_valid,
    output logic          out_last,
    output logic [IW-1:0] out_idx,
    output logic [W-1:0]  out_data,
    output logic          out_nz
);

    logic          v_s    [LAT+1];
    logic          last_s [LAT+1];
    logic [IW-1:0] idx_s  [LAT+1];
    logic [W-1:0]  dat_s  [LAT+1];
    logic          nz_s   [LAT+1];

    assign v_s[0]    = in_valid;
    assign last_s[0] = in_last;
    assign idx_s[0]  = in_idx;
    assign dat_s[0]  = in_data;
    assign nz_s[0]   = in_nz;

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_s[s+1]    <= 1'b0;
                last_s[s+1] <= 1'b0;
            end else begin
                v_s[s+1]    <= v_s[s];
                last_s[s+1] <= v_s[s] && last_s[s];
            end
        end
        always_ff @(posedge clk) begin
            idx_s[s+1] <= idx_s[s];
            dat_s[s+1] <= dat_s[s];
            nz_s[s+1]  <= nz_s[s];
        end
    end

    assign out_valid = v_s[LAT];
    assign out_last  = last_s[LAT];
    assign out_idx   = idx_s[LAT];
    assign out_data  = dat_s[LAT];
    assign out_nz    = nz_s[LAT];

endmodule

// File: rtl/vlu_reduce.sv
module vlu_reduce #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         acc_en,
    input  logic         nz,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else if (acc_en && nz) count <= count + W'(1);
    end

endmodule

// File: rtl/vec_lane_unit.sv
module vec_lane_unit
    import vlu_pkg::*;
#(
    parameter int W     = 16,
    parameter int VLEN  = 8,
    parameter int NVREG = 8,
    parameter int NSREG = 8,
    parameter int LAT   = 3,
    localparam int IW   = (VLEN > 1) ? $clog2(VLEN) : 1,
    localparam int RW   = (NVREG > 1) ? $clog2(NVREG) : 1,
    localparam int SW   = (NSREG > 1) ? $clog2(NSREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  logic [2:0]    issue_op,
    input  logic [RW-1:0] issue_vd,
    input  logic [RW-1:0] issue_va,
    input  logic [RW-1:0] issue_vb,
    input  logic [SW-1:0] issue_sd,
    input  logic [W-1:0]  issue_scalar,
    output logic          issue_ready,
    output logic          rd_en,
    output logic [RW-1:0] rd_a_reg,
    output logic [RW-1:0] rd_b_reg,
    output logic [IW-1:0] rd_idx,
    input  logic [W-1:0]  rd_a_data,
    input  logic [W-1:0]  rd_b_data,
    output logic          wr_en,
    output logic [RW-1:0] wr_reg,
    output logic [IW-1:0] wr_idx,
    output logic [W-1:0]  wr_data,
    output logic          sres_valid,
    output logic [SW-1:0] sres_reg,
    output logic [W-1:0]  sres_data
);

    logic          start, rd_last, report;
    logic [2:0]    op_q;
    logic [RW-1:0] vd_q, va_q, vb_q;
    logic [SW-1:0] sd_q;
    logic [W-1:0]  scalar_q;
    logic [W-1:0]  ex_result;
    logic          ex_nz;
    logic          po_valid, po_last, po_nz;
    logic [IW-1:0] po_idx;
    logic [W-1:0]  po_data;
    logic [W-1:0]  pop_count;

    vlu_ctrl #(.VLEN(VLEN), .IW(IW), .RW(RW), .SW(SW), .W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_vd(issue_vd), .issue_va(issue_va), .issue_vb(issue_vb),
        .issue_sd(issue_sd), .issue_scalar(issue_scalar),
        .pipe_out_valid(po_valid), .pipe_out_last(po_last),
        .issue_ready(issue_ready), .start(start),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_last(rd_last), .report(report),
        .op_q(op_q), .vd_q(vd_q), .va_q(va_q), .vb_q(vb_q),
        .sd_q(sd_q), .scalar_q(scalar_q)
    );

    vlu_exec #(.W(W)) u_exec (
        .op(op_q), .a(rd_a_data), .b_vec(rd_b_data), .scalar(scalar_q),
        .result(ex_result), .nonzero(ex_nz)
    );

    vlu_pipe #(.LAT(LAT), .W(W), .IW(IW)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rd_en), .in_last(rd_last), .in_idx(rd_idx),
        .in_data(ex_result), .in_nz(ex_nz),
        .out_valid(po_valid), .out_last(po_last), .out_idx(po_idx),
        .out_data(po_data), .out_nz(po_nz)
    );

    vlu_reduce #(.W(W)) u_reduce (
        .clk(clk), .rst_n(rst_n), .clear(start),
        .acc_en(po_valid && op_is_popc(op_q)), .nz(po_nz),
        .count(pop_count)
    );

    assign rd_a_reg   = va_q;
    assign rd_b_reg   = vb_q;
    assign wr_en      = po_valid && !op_is_popc(op_q);
    assign wr_reg     = vd_q;
    assign wr_idx     = po_idx;
    assign wr_data    = po_data;
    assign sres_valid = report;
    assign sres_reg   = sd_q;
    assign sres_data  = pop_count;

endmodule

// File: rtl/vlu_checker.sv
module vlu_checker #(
    parameter int IW   = 3,
    parameter int VLEN = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue_valid,
    input logic [2:0]    issue_op,
    input logic          issue_ready,
    input logic          rd_en,
    input logic [IW-1:0] rd_idx,
    input logic          wr_en,
    input logic [IW-1:0] wr_idx,
    input logic          sres_valid
);

    localparam logic [IW-1:0] LAST_IDX = IW'(VLEN - 1);

    AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !issue_ready); // R9
    AST_RD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !issue_ready); // R9
    AST_WR_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_idx == $past(wr_idx) + IW'(1))); // R8
    AST_RD_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_idx == $past(rd_idx) + IW'(1))); // R8
    AST_SRES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sres_valid |=> !sres_valid); // R7
    AST_SRES_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sres_valid |-> !wr_en); // R7
    AST_FREE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == LAST_IDX) |=> issue_ready); // R9
    AST_ILLEGAL_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ready && issue_valid && issue_op > 3'b100) |=> issue_ready); // R10

endmodule

bind vec_lane_unit vlu_checker #(.IW(IW), .VLEN(VLEN)) u_vlu_checker (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_ready(issue_ready), .rd_en(rd_en), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .sres_valid(sres_valid)
);

// File: tb/vec_lane_unit_bench.sv
module vec_lane_unit_bench;

    localparam int W = 16, VLEN = 8, NVREG = 8, NSREG = 8, LAT = 3;
    localparam int NT = 8;
    // entry: {op[3], vd/sd[3], va[3], vb[3], scalar[16]}
    localparam logic [27:0] TBL [NT] = '{
        {3'b000, 3'd1, 3'd2, 3'd6, 16'h0000},
        {3'b001, 3'd4, 3'd6, 3'd0, 16'h0020},
        {3'b010, 3'd5, 3'd2, 3'd6, 16'h0000},
        {3'b011, 3'd0, 3'd6, 3'd0, 16'h0003},
        {3'b100, 3'd2, 3'd3, 3'd0, 16'h0000},
        {3'b100, 3'd5, 3'd6, 3'd0, 16'h0000},
        {3'b100, 3'd6, 3'd7, 3'd0, 16'h0000},
        {3'b000, 3'd2, 3'd2, 3'd2, 16'h0000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic issue_valid = 1'b0;
    logic [2:0] issue_op = '0, issue_vd = '0, issue_va = '0, issue_vb = '0, issue_sd = '0;
    logic [W-1:0] issue_scalar = '0;
    logic issue_ready, rd_en, wr_en, sres_valid;
    logic [2:0] rd_a_reg, rd_b_reg, rd_idx, wr_reg, wr_idx, sres_reg;
    logic [W-1:0] rd_a_data, rd_b_data, wr_data, sres_data;
    logic [W-1:0] vrf [NVREG][VLEN];
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    vec_lane_unit #(.W(W), .VLEN(VLEN), .NVREG(NVREG), .NSREG(NSREG), .LAT(LAT)) u_vec_lane_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_vd(issue_vd), .issue_va(issue_va), .issue_vb(issue_vb),
        .issue_sd(issue_sd), .issue_scalar(issue_scalar), .issue_ready(issue_ready),
        .rd_en(rd_en), .rd_a_reg(rd_a_reg), .rd_b_reg(rd_b_reg), .rd_idx(rd_idx),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_reg(wr_reg),
        .wr_idx(wr_idx), .wr_data(wr_data), .sres_valid(sres_valid),
        .sres_reg(sres_reg), .sres_data(sres_data)
    );

    assign rd_a_data = vrf[rd_a_reg][rd_idx];
    assign rd_b_data = vrf[rd_b_reg][rd_idx];
    always @(posedge clk) if (wr_en) vrf[wr_reg][wr_idx] <= wr_data;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'b000:  return "R2";
            3'b001:  return "R3";
            3'b010:  return "R4";
            3'b011:  return "R5";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [W-1:0] model(input logic [2:0] op, input logic [W-1:0] a,
                                           input logic [W-1:0] b, input logic [W-1:0] s);
        case (op)
            3'b000:  return a + b;
            3'b001:  return a + s;
            3'b010:  return a * b;
            default: return a * s;
        endcase
    endfunction

    // Issues one operation and follows it cycle by cycle until the unit is idle.
    // If intrude > 0, a second issue targeting register 7 is presented at that cycle.
    task automatic run_op(input logic [2:0] op, input logic [2:0] vd, input logic [2:0] va,
                          input logic [2:0] vb, input logic [W-1:0] sc, input int intrude);
        logic [W-1:0] exp_v [VLEN];
        int exp_cnt = 0;
        bit pop = (op == 3'b100);
        bit tim_ok = 1, rdy_ok = 1, nowr_ok = 1, sres_seen = 0;
        int busy_end = VLEN + LAT + (pop ? 1 : 0);
        for (int i = 0; i < VLEN; i++) begin
            exp_v[i] = model(op, vrf[va][i], vrf[vb][i], sc);
            if (vrf[va][i] != '0) exp_cnt++;
        end
        @(negedge clk);
        issue_valid = 1; issue_op = op; issue_vd = vd; issue_sd = vd;
        issue_va = va; issue_vb = vb; issue_scalar = sc;
        @(negedge clk);
        issue_valid = 0; issue_scalar = 16'hBEEF; // R6: scalar port changes after accept
        for (int t = 1; t <= VLEN + LAT + 2; t++) begin
            bit expw = !pop && (t >= LAT + 1) && (t <= VLEN + LAT);
            if (wr_en !== expw) begin tim_ok = 0; if (pop) nowr_ok = 0; end
            if (expw && (wr_idx !== 3'(t - 1 - LAT) || wr_reg !== vd)) tim_ok = 0;
            if (issue_ready !== (t > busy_end)) rdy_ok = 0;
            if (sres_valid === 1'b1) begin
                check(pop && t == VLEN + LAT + 1 && !sres_seen, "R7", "sres_valid cycle", t, VLEN + LAT + 1);
                check(sres_data == W'(exp_cnt), "R7", "count", sres_data, exp_cnt);
                check(sres_reg == vd, "R7", "sres_reg", sres_reg, vd);
                sres_seen = 1;
            end
            if (t == intrude) begin
                issue_valid = 1; issue_op = 3'b000; issue_vd = 3'd7; issue_va = 3'd0; issue_vb = 3'd0;
            end else begin
                issue_valid = 0;
            end
            @(negedge clk);
        end
        check(tim_ok, "R8", "write timing/order", tim_ok, 1);
        check(rdy_ok, "R9", "busy window", rdy_ok, 1);
        if (pop) begin
            check(sres_seen, "R7", "scalar result seen", sres_seen, 1);
            check(nowr_ok, "R7", "no vector write", nowr_ok, 1);
        end else begin
            bit all_ok = 1;
            for (int i = 0; i < VLEN; i++) begin
                check(vrf[vd][i] == exp_v[i], req_of(op), "element", vrf[vd][i], exp_v[i]);
                if (vrf[vd][i] != exp_v[i]) all_ok = 0;
            end
            if (op == 3'b001 || op == 3'b011)
                check(all_ok, "R6", "scalar held from issue", all_ok, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < NVREG; r++)
            for (int i = 0; i < VLEN; i++)
                vrf[r][i] = W'(r * 37 + i * 1001 + 5);
        for (int i = 0; i < VLEN; i++) begin
            vrf[6][i] = W'(16'hFFF0 + i);
            vrf[7][i] = '0;
            if (i % 3 == 0) vrf[3][i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(issue_ready === 1'b1, "R1", "issue_ready", issue_ready, 1);
        check(rd_en === 1'b0, "R1", "rd_en", rd_en, 0);
        check(wr_en === 1'b0, "R1", "wr_en", wr_en, 0);
        check(sres_valid === 1'b0, "R1", "sres_valid", sres_valid, 0);
        rst_n = 1;

        for (int k = 0; k < NT; k++)
            run_op(TBL[k][27:25], TBL[k][24:22], TBL[k][21:19], TBL[k][18:16], TBL[k][15:0], 0);

        // R9: intruding issue during busy is ignored
        run_op(3'b010, 3'd1, 3'd4, 3'd5, 16'h0, 3);
        for (int i = 0; i < VLEN; i++)
            check(vrf[7][i] == '0, "R9", "reg7 untouched", vrf[7][i], 0);

        // R10: illegal opcode not accepted
        begin
            bit quiet = 1;
            @(negedge clk);
            issue_valid = 1; issue_op = 3'b101; issue_vd = 3'd7; issue_va = 3'd1;
            @(negedge clk);
            issue_valid = 0;
            check(issue_ready === 1'b1, "R10", "still idle", issue_ready, 1);
            for (int t = 0; t < VLEN + LAT + 3; t++) begin
                if (rd_en || wr_en || sres_valid) quiet = 0;
                @(negedge clk);
            end
            check(quiet, "R10", "no activity", quiet, 1);
        end

        // R1: reset in the middle of an operation
        @(negedge clk);
        issue_valid = 1; issue_op = 3'b000; issue_vd = 3'd3; issue_va = 3'd1; issue_vb = 3'd1;
        @(negedge clk);
        issue_valid = 0;
        repeat (2) @(negedge clk);
        check(issue_ready === 1'b0, "R9", "busy before reset", issue_ready, 0);
        rst_n = 0;
        @(negedge clk);
        check(issue_ready === 1'b1, "R1", "idle after reset", issue_ready, 1);
        check(rd_en === 1'b0 && wr_en === 1'b0, "R1", "no rd/wr after reset", {rd_en, wr_en}, 0);
        rst_n = 1;
        @(negedge clk);
        check(sres_valid === 1'b0 && wr_en === 1'b0, "R1", "quiet after release", {sres_valid, wr_en}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule